// File: doc/BRIEF.md
# Road Hit Combiner

This block sits between a hit stream, a pattern matcher and a track fitter. While an event's full-resolution hits stream in, each one is kept locally in a database. The database is indexed by detector layer and superstrip ID. Only the hit's coarse superstrip ID is passed on, one cycle later, to the pattern matcher. When the matcher reports a matched road, the block looks the road ID up in a road table. The table turns the road into one superstrip ID per layer. The block then copies the stored hits of those superstrips into a local working set and emits every combination that takes one hit from each layer as a candidate track, one candidate per clock.

A road is taken through a valid/ready handshake. The control is a four-state machine:

- `S_IDLE` waits for a road. `road_ready` is high only in this state. The transition *accept* goes to `S_DECODE`.
- `S_DECODE` performs the registered table read. The transition *decoded* goes to `S_FETCH`.
- `S_FETCH` copies the per-layer hit lists and their lengths. From here the transition *skip* returns to `S_IDLE` when any layer's list is empty. Otherwise the transition *start* goes to `S_ENUM`.
- `S_ENUM` steps a mixed-radix counter, one candidate per cycle. The transition *advance* stays in `S_ENUM`, and the transition *done* returns to `S_IDLE` after the final combination.

A separate end-of-event pulse empties the database.

Top module: `road_combiner`

## Requirements
- R1: Every cycle with `hit_valid` high is reproduced one cycle later on `ss_out_valid`, `ss_out_layer` and `ss_out_id` with the same layer and superstrip ID, whether or not the hit is stored. With `hit_valid` low, `ss_out_valid` is low in the next cycle.
- R2: Within one event, each (layer, superstrip) keeps at most SLOTS hits (default 4) in arrival order. Further hits to that superstrip are not stored and never appear in a candidate.
- R3: A write with `tbl_we` stores `tbl_data` for road `tbl_addr`. Bits `[l*SS_W +: SS_W]` hold the superstrip ID of layer l.
- R4: For a road whose decoded superstrips all hold hits, the number of candidates equals the product of the per-layer hit counts. Each candidate holds one stored hit per layer, with layer l in `cand_hits[l*HIT_W +: HIT_W]`.
- R5: Candidates come in mixed-radix order. The highest-numbered layer varies fastest. Within a layer, hits are taken in arrival order.
- R6: When a road is accepted at a rising edge, the first candidate is valid after the second rising edge that follows. Candidates are then valid on consecutive cycles with no gap, and `cand_road` carries the accepted road ID.
- R7: If any layer of the decoded road holds no hits, the road produces no candidate. `road_ready` is high again two edges after acceptance.
- R8: `road_ready` is low from the edge that accepts a road until the enumeration ends. `cand_last` is high only on the final candidate, and in the next cycle `cand_valid` is low and `road_ready` is high.
- R9: A cycle with `event_end` high empties every superstrip. A hit presented in the same cycle is stored as the first hit of the new event.
- R10: After reset, `road_ready` is high, `cand_valid` and `ss_out_valid` are low, and the database is empty.
- R11: Hit lists are copied in `S_FETCH`, so an `event_end` or new hits arriving during `S_ENUM` do not change the candidates of the road being enumerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_layer | input | LAY_W | Layer of the hit |
| hit_ss | input | SS_W | Superstrip ID of the hit |
| hit_coord | input | HIT_W | Full-resolution coordinate of the hit |
| event_end | input | 1 | End-of-event pulse, empties the database |
| ss_out_valid | output | 1 | Forwarded superstrip ID valid |
| ss_out_layer | output | LAY_W | Forwarded layer |
| ss_out_id | output | SS_W | Forwarded superstrip ID for the pattern matcher |
| tbl_we | input | 1 | Road table write enable |
| tbl_addr | input | ROAD_W | Road table write address (road ID) |
| tbl_data | input | NUM_LAYERS*SS_W | Per-layer superstrip IDs for the road |
| road_valid | input | 1 | A matched road ID is offered |
| road_id | input | ROAD_W | Matched road ID |
| road_ready | output | 1 | Block can take a road |
| cand_valid | output | 1 | Candidate track valid |
| cand_road | output | ROAD_W | Road that produced the candidate |
| cand_hits | output | NUM_LAYERS*HIT_W | One hit coordinate per layer |
| cand_last | output | 1 | Final candidate of the road |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is clearing and storing. The bench raises `event_end` together with a new hit. It then decodes a road that uses that superstrip, and judges the case by the single candidate that must carry the new hit and none of the old ones.

The second pair is clearing and enumerating. An `event_end` pulse is driven in the middle of a road's enumeration. All eight candidates must still come out intact, and a later road over the same superstrips must then yield none.

// File: rtl/road_combiner_pkg.sv
package road_combiner_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DECODE,
        S_FETCH,
        S_ENUM
    } comb_state_e;

endpackage

// File: rtl/road_combiner_store.sv
module road_combiner_store #(
    parameter int NUM_LAYERS = 4,
    parameter int SS_W       = 4,
    parameter int HIT_W      = 8,
    parameter int SLOTS      = 4,
    parameter int LAY_W      = 2,
    parameter int CNT_W      = 3,
    parameter int IDX_W      = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hit_valid,
    input  logic [LAY_W-1:0]                  hit_layer,
    input  logic [SS_W-1:0]                   hit_ss,
    input  logic [HIT_W-1:0]                  hit_coord,
    input  logic                              event_end,
    output logic                              ss_out_valid,
    output logic [LAY_W-1:0]                  ss_out_layer,
    output logic [SS_W-1:0]                   ss_out_id,
    input  logic [NUM_LAYERS*SS_W-1:0]        rd_ss,
    output logic [NUM_LAYERS*CNT_W-1:0]       rd_cnt,
    output logic [NUM_LAYERS*SLOTS*HIT_W-1:0] rd_hits
);

    localparam int NUM_SS = 1 << SS_W;

    // forward coarse ID towards the pattern matcher
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_out_valid <= 1'b0;
            ss_out_layer <= '0;
            ss_out_id    <= '0;
        end else begin
            ss_out_valid <= hit_valid;
            if (hit_valid) begin
                ss_out_layer <= hit_layer;
                ss_out_id    <= hit_ss;
            end
        end
    end

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        logic [CNT_W-1:0] cnt_q  [NUM_SS];
        logic [HIT_W-1:0] slot_q [NUM_SS][SLOTS];
        logic             here;
        logic             wr_ok;
        logic [CNT_W-1:0] cur_cnt;
        logic [CNT_W-1:0] new_cnt;
        logic [IDX_W-1:0] wr_idx;
        logic [SS_W-1:0]  sel_ss;

        always_comb begin
            here    = hit_valid && (hit_layer == LAY_W'(l));
            cur_cnt = cnt_q[hit_ss];
            wr_ok   = here && (event_end || (cur_cnt < CNT_W'(SLOTS)));
            wr_idx  = event_end ? '0 : cur_cnt[IDX_W-1:0];
            new_cnt = event_end ? CNT_W'(1) : cur_cnt + CNT_W'(1);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < NUM_SS; s++) cnt_q[s] <= '0;
            end else begin
                if (event_end) begin
                    for (int s = 0; s < NUM_SS; s++) cnt_q[s] <= '0;
                end
                if (wr_ok) cnt_q[hit_ss] <= new_cnt;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_ok) slot_q[hit_ss][wr_idx] <= hit_coord;
        end

        assign sel_ss = rd_ss[l*SS_W +: SS_W];
        assign rd_cnt[l*CNT_W +: CNT_W] = cnt_q[sel_ss];

        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            assign rd_hits[(l*SLOTS + k)*HIT_W +: HIT_W] = slot_q[sel_ss][k];
        end
    end

endmodule

// File: rtl/road_combiner_table.sv
module road_combiner_table #(
    parameter int ROAD_W = 6,
    parameter int TBL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROAD_W-1:0] wr_addr,
    input  logic [TBL_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ROAD_W-1:0] rd_addr,
    output logic [TBL_W-1:0]  rd_data
);

    localparam int NUM_ROADS = 1 << ROAD_W;

    logic [TBL_W-1:0] mem [NUM_ROADS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/road_combiner_enum.sv
module road_combiner_enum
    import road_combiner_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int HIT_W      = 8,
    parameter int SLOTS      = 4,
    parameter int ROAD_W     = 6,
    parameter int CNT_W      = 3,
    parameter int IDX_W      = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              road_valid,
    input  logic [ROAD_W-1:0]                 road_id,
    output logic                              road_ready,
    output logic                              tbl_rd_en,
    output logic [ROAD_W-1:0]                 tbl_rd_addr,
    input  logic [NUM_LAYERS*CNT_W-1:0]       rd_cnt,
    input  logic [NUM_LAYERS*SLOTS*HIT_W-1:0] rd_hits,
    output logic                              cand_valid,
    output logic [ROAD_W-1:0]                 cand_road,
    output logic [NUM_LAYERS*HIT_W-1:0]       cand_hits,
    output logic                              cand_last
);

    comb_state_e state_q, state_nx;

    logic [ROAD_W-1:0]                 road_q;
    logic [NUM_LAYERS*SLOTS*HIT_W-1:0] list_q;
    logic [CNT_W-1:0]                  len_q [NUM_LAYERS];
    logic [IDX_W-1:0]                  dig_q [NUM_LAYERS];
    logic [IDX_W-1:0]                  dig_nx [NUM_LAYERS];
    logic                              any_empty;
    logic                              all_max;
    logic                              carry;
    logic                              at_max;

    always_comb begin
        any_empty = 1'b0;
        for (int l = 0; l < NUM_LAYERS; l++) begin
            if (rd_cnt[l*CNT_W +: CNT_W] == '0) any_empty = 1'b1;
        end
    end

    // mixed-radix step, highest layer is the least significant digit
    always_comb begin
        carry   = 1'b1;
        all_max = 1'b1;
        at_max  = 1'b0;
        for (int l = NUM_LAYERS - 1; l >= 0; l--) begin
            at_max = (CNT_W'(dig_q[l]) == (len_q[l] - CNT_W'(1)));
            if (!at_max) all_max = 1'b0;
            if (carry) begin
                if (at_max) begin
                    dig_nx[l] = '0;
                end else begin
                    dig_nx[l] = dig_q[l] + IDX_W'(1);
                    carry     = 1'b0;
                end
            end else begin
                dig_nx[l] = dig_q[l];
            end
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:   if (road_valid) state_nx = S_DECODE;
            S_DECODE: state_nx = S_FETCH;
            S_FETCH:  state_nx = any_empty ? S_IDLE : S_ENUM;
            S_ENUM:   if (all_max) state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            road_q <= '0;
            list_q <= '0;
            for (int l = 0; l < NUM_LAYERS; l++) begin
                len_q[l] <= '0;
                dig_q[l] <= '0;
            end
        end else begin
            if (state_q == S_IDLE && road_valid) road_q <= road_id;
            if (state_q == S_FETCH) begin
                list_q <= rd_hits;
                for (int l = 0; l < NUM_LAYERS; l++) begin
                    len_q[l] <= rd_cnt[l*CNT_W +: CNT_W];
                    dig_q[l] <= '0;
                end
            end else if (state_q == S_ENUM && !all_max) begin
                for (int l = 0; l < NUM_LAYERS; l++) dig_q[l] <= dig_nx[l];
            end
        end
    end

    always_comb begin
        road_ready  = (state_q == S_IDLE);
        tbl_rd_en   = (state_q == S_DECODE);
        tbl_rd_addr = road_q;
        cand_valid  = (state_q == S_ENUM);
        cand_last   = (state_q == S_ENUM) && all_max;
        cand_road   = road_q;
        for (int l = 0; l < NUM_LAYERS; l++) begin
            cand_hits[l*HIT_W +: HIT_W] =
                list_q[(l*SLOTS + int'(dig_q[l]))*HIT_W +: HIT_W];
        end
    end

endmodule

// File: rtl/road_combiner.sv
module road_combiner #(
    parameter int NUM_LAYERS = 4,
    parameter int SS_W       = 4,
    parameter int HIT_W      = 8,
    parameter int SLOTS      = 4,
    parameter int ROAD_W     = 6,
    localparam int LAY_W     = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int TBL_W     = NUM_LAYERS * SS_W,
    localparam int CAND_W    = NUM_LAYERS * HIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [LAY_W-1:0]  hit_layer,
    input  logic [SS_W-1:0]   hit_ss,
    input  logic [HIT_W-1:0]  hit_coord,
    input  logic              event_end,
    output logic              ss_out_valid,
    output logic [LAY_W-1:0]  ss_out_layer,
    output logic [SS_W-1:0]   ss_out_id,
    input  logic              tbl_we,
    input  logic [ROAD_W-1:0] tbl_addr,
    input  logic [TBL_W-1:0]  tbl_data,
    input  logic              road_valid,
    input  logic [ROAD_W-1:0] road_id,
    output logic              road_ready,
    output logic              cand_valid,
    output logic [ROAD_W-1:0] cand_road,
    output logic [CAND_W-1:0] cand_hits,
    output logic              cand_last
);

    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic                              tbl_rd_en;
    logic [ROAD_W-1:0]                 tbl_rd_addr;
    logic [TBL_W-1:0]                  road_ss;
    logic [NUM_LAYERS*CNT_W-1:0]       rd_cnt;
    logic [NUM_LAYERS*SLOTS*HIT_W-1:0] rd_hits;

    road_combiner_store #(
        .NUM_LAYERS(NUM_LAYERS), .SS_W(SS_W), .HIT_W(HIT_W), .SLOTS(SLOTS),
        .LAY_W(LAY_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .hit_valid(hit_valid), .hit_layer(hit_layer), .hit_ss(hit_ss),
        .hit_coord(hit_coord), .event_end(event_end),
        .ss_out_valid(ss_out_valid), .ss_out_layer(ss_out_layer),
        .ss_out_id(ss_out_id),
        .rd_ss(road_ss), .rd_cnt(rd_cnt), .rd_hits(rd_hits)
    );

    road_combiner_table #(
        .ROAD_W(ROAD_W), .TBL_W(TBL_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_data),
        .rd_en(tbl_rd_en), .rd_addr(tbl_rd_addr), .rd_data(road_ss)
    );

    road_combiner_enum #(
        .NUM_LAYERS(NUM_LAYERS), .HIT_W(HIT_W), .SLOTS(SLOTS),
        .ROAD_W(ROAD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_enum (
        .clk(clk), .rst_n(rst_n),
        .road_valid(road_valid), .road_id(road_id), .road_ready(road_ready),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
        .rd_cnt(rd_cnt), .rd_hits(rd_hits),
        .cand_valid(cand_valid), .cand_road(cand_road),
        .cand_hits(cand_hits), .cand_last(cand_last)
    );

endmodule

// File: rtl/road_combiner_chk.sv
module road_combiner_chk #(
    parameter int NUM_LAYERS = 4,
    parameter int SS_W       = 4,
    parameter int ROAD_W     = 6,
    localparam int LAY_W     = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit_valid,
    input logic [LAY_W-1:0]  hit_layer,
    input logic [SS_W-1:0]   hit_ss,
    input logic              ss_out_valid,
    input logic [LAY_W-1:0]  ss_out_layer,
    input logic [SS_W-1:0]   ss_out_id,
    input logic              road_valid,
    input logic              road_ready,
    input logic              cand_valid,
    input logic              cand_last,
    input logic [ROAD_W-1:0] cand_road
);

    assert_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> ss_out_valid && ss_out_layer == $past(hit_layer)
                      && ss_out_id == $past(hit_ss));

    assert_no_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> !ss_out_valid);

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> !road_ready);

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        road_valid && road_ready |=> !road_ready && !cand_valid);

    assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && cand_last |=> !cand_valid && road_ready);

    assert_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && !cand_last |=> cand_valid && cand_road == $past(cand_road));

endmodule

bind road_combiner road_combiner_chk #(
    .NUM_LAYERS(NUM_LAYERS), .SS_W(SS_W), .ROAD_W(ROAD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .hit_valid(hit_valid), .hit_layer(hit_layer), .hit_ss(hit_ss),
    .ss_out_valid(ss_out_valid), .ss_out_layer(ss_out_layer),
    .ss_out_id(ss_out_id),
    .road_valid(road_valid), .road_ready(road_ready),
    .cand_valid(cand_valid), .cand_last(cand_last), .cand_road(cand_road)
);

// File: tb/tb_road_combiner.sv
module tb_road_combiner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid = 1'b0;
    logic [1:0]  hit_layer = '0;
    logic [3:0]  hit_ss = '0;
    logic [7:0]  hit_coord = '0;
    logic        event_end = 1'b0;
    logic        ss_out_valid;
    logic [1:0]  ss_out_layer;
    logic [3:0]  ss_out_id;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        road_valid = 1'b0;
    logic [5:0]  road_id = '0;
    logic        road_ready;
    logic        cand_valid;
    logic [5:0]  cand_road;
    logic [31:0] cand_hits;
    logic        cand_last;

    int checks = 0;
    int errors = 0;

    // bench model built from the requirements
    int         m_cnt [4][16];
    logic [7:0] m_hit [4][16][4];
    logic [15:0] m_tbl [64];

    // stimulus/expected vectors: {road id, expected candidate count}
    localparam logic [13:0] ROAD_VEC [5] = '{
        {6'd1, 8'd12}, {6'd2, 8'd0}, {6'd3, 8'd1}, {6'd4, 8'd8}, {6'd1, 8'd12}
    };

    road_combiner dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 16; s++) m_cnt[l][s] = 0;
    endtask

    task automatic send_hit(input int l, input int s, input logic [7:0] c,
                            input bit eoe);
        @(negedge clk);
        hit_valid = 1'b1; hit_layer = 2'(l); hit_ss = 4'(s); hit_coord = c;
        event_end = eoe;
        if (eoe) model_clear();
        if (m_cnt[l][s] < 4) begin
            m_hit[l][s][m_cnt[l][s]] = c;
            m_cnt[l][s]++;
        end
        @(negedge clk);
        chk(ss_out_valid && ss_out_layer == 2'(l) && ss_out_id == 4'(s), "R1",
            "forwarded layer/ss", {ss_out_valid, ss_out_layer, ss_out_id},
            {1'b1, 2'(l), 4'(s)});
        hit_valid = 1'b0; event_end = 1'b0;
    endtask

    task automatic write_road(input int r, input logic [15:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 6'(r); tbl_data = d;
        m_tbl[r] = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run_road(input int rid, input int exp_n, input bit mid_clear,
                            input string req);
        logic [31:0] exp_c [64];
        int n = 0;
        int got = 0;
        int first_i = -1;
        int prev_i = -1;
        int s0 = int'(m_tbl[rid][3:0]);
        int s1 = int'(m_tbl[rid][7:4]);
        int s2 = int'(m_tbl[rid][11:8]);
        int s3 = int'(m_tbl[rid][15:12]);
        for (int a = 0; a < m_cnt[0][s0]; a++)
            for (int b = 0; b < m_cnt[1][s1]; b++)
                for (int c = 0; c < m_cnt[2][s2]; c++)
                    for (int d = 0; d < m_cnt[3][s3]; d++) begin
                        if (n < 64) exp_c[n] = {m_hit[3][s3][d], m_hit[2][s2][c],
                                                m_hit[1][s1][b], m_hit[0][s0][a]};
                        n++;
                    end
        @(negedge clk);
        while (!road_ready) @(negedge clk);
        road_valid = 1'b1; road_id = 6'(rid);
        @(negedge clk);
        road_valid = 1'b0;
        chk(!road_ready, "R8", "ready low after accept", road_ready, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            event_end = (mid_clear && i == 3);
            if (mid_clear && i == 3) model_clear();
            if (cand_valid) begin
                if (got == 0) first_i = i;
                if (got > 0)
                    chk(i == prev_i + 1, "R6", "gap between candidates", i, prev_i + 1);
                if (got < n && got < 64)
                    chk(cand_hits == exp_c[got], req, "candidate hits", cand_hits, exp_c[got]);
                else
                    chk(1'b0, req, "extra candidate", got, n);
                chk(cand_road == 6'(rid), "R6", "cand_road", cand_road, rid);
                chk(cand_last == (got == exp_n - 1), "R8", "cand_last", cand_last,
                    (got == exp_n - 1));
                chk(!road_ready, "R8", "ready during enumeration", road_ready, 0);
                prev_i = i;
                got++;
            end
        end
        event_end = 1'b0;
        chk(got == exp_n, (exp_n == 0) ? "R7" : "R4", "candidate count", got, exp_n);
        if (exp_n > 0) chk(first_i == 1, "R6", "first candidate latency", first_i, 1);
        chk(road_ready, "R8", "ready after road", road_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(road_ready, "R10", "road_ready", road_ready, 1);
        chk(!cand_valid, "R10", "cand_valid", cand_valid, 0);
        chk(!ss_out_valid, "R10", "ss_out_valid", ss_out_valid, 0);

        // R3 road table: layer l at bits [4l +: 4]
        write_road(1, 16'h1752);
        write_road(2, 16'h1753);
        write_road(3, 16'h0000);
        write_road(4, 16'h9852);
        write_road(5, 16'h0002);

        // R10 database empty after reset: road 5 finds nothing
        run_road(5, 0, 1'b0, "R10");

        send_hit(0, 2, 8'h10, 0); send_hit(0, 2, 8'h11, 0);
        send_hit(1, 5, 8'h20, 0);
        send_hit(2, 7, 8'h30, 0); send_hit(2, 7, 8'h31, 0); send_hit(2, 7, 8'h32, 0);
        send_hit(3, 1, 8'h40, 0); send_hit(3, 1, 8'h41, 0);
        send_hit(2, 8, 8'h33, 0);
        for (int k = 0; k < 4; k++) send_hit(3, 9, 8'(8'h50 + k), 0);
        send_hit(3, 9, 8'h54, 0);  // R2 fifth hit dropped, still forwarded
        send_hit(0, 0, 8'h01, 0); send_hit(1, 0, 8'h02, 0);
        send_hit(2, 0, 8'h03, 0); send_hit(3, 0, 8'h04, 0);

        // table walk: R4 R5 R7 and R2 (road 4 has the overflowed superstrip)
        for (int v = 0; v < 5; v++)
            run_road(int'(ROAD_VEC[v][13:8]), int'(ROAD_VEC[v][7:0]), 1'b0, "R5");

        // R11 clear during enumeration leaves current road intact
        run_road(4, 8, 1'b1, "R11");
        // R9 database empty after clear
        run_road(1, 0, 1'b0, "R9");

        // R9 clear and store in the same cycle
        send_hit(0, 0, 8'h66, 0);
        send_hit(0, 0, 8'h77, 1);
        send_hit(1, 0, 8'h12, 0); send_hit(2, 0, 8'h13, 0); send_hit(3, 0, 8'h14, 0);
        run_road(3, 1, 1'b0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule